// File: doc/BRIEF.md
# Windowed Watchdog Counter Core

This block is the counting engine of a windowed watchdog timer. An up-counter advances on a prescaled version of the function clock. When the count reaches a programmable warning threshold, the block raises an interrupt request. When it reaches a second threshold, it raises a reset request. Software keeps the watchdog alive by writing a fixed 32-bit service word to the refresh port. A good refresh returns the count to zero and drops both requests. Any other write is flagged as a refresh violation.

When window mode is on, a refresh is accepted only while the count lies inside a window derived from the reset threshold. The window has a fractional lower bound and an optional upper bound. Two further controls scale or stop counting: a low-power rate setting and a debug hold. The reset request can be set to release itself after a fixed number of cycles. Register decoding and clock-domain crossing belong to the surrounding logic. This core takes its configuration as plain input fields.

Top module: `winwdt_core`

## Requirements
- R1: A cycle is "eligible" when `runEn` is 1, the debug hold is not in force and the low-power gate allows it. Counting starts from a fresh reset or a valid refresh. After that, `count` advances by one on every 2^`divSel` eligible cycles. It saturates at all ones.
- R2: If `irqEn` is 1 and `runEn` is 1, `irqReq` rises one clock after the clock edge at which `count` first becomes greater than or equal to `irqThresh`. With `irqEn` at 0, `irqReq` never rises.
- R3: If `rstEn` is 1 and `runEn` is 1, `rstReq` rises one clock after the clock edge at which `count` first becomes greater than or equal to `rstThresh`. With `rstEn` at 0, `rstReq` never rises.
- R4: A valid refresh is a `refWr` cycle whose `refData` equals 32'h5A45524F and which meets the window rule (R6, R7). At the next clock edge it sets `count` to 0 and clears both `irqReq` and `rstReq`. It takes priority over a threshold hit at that same edge.
- R5: A `refWr` cycle that is not a valid refresh makes `refViol` high for exactly the following clock. It leaves `count`, `irqReq` and `rstReq` untouched.
- R6: With `winEn` at 1, a refresh is rejected when `count` is below the lower bound. The lower bound is floor(`rstThresh` × (4 + `winLowSel`) / 8), so codes 0 to 3 select 4/8 to 7/8 of the threshold.
- R7: With `winEn` at 1 and `winUpSel` nonzero, a refresh is also rejected when `count` is above lower bound + floor(`rstThresh`/16) × `winUpSel`. With `winUpSel` at 0 there is no upper bound.
- R8: While `lpActive` is 1, `lpMode` sets the rate: 2'b00 stops counting, 2'b01 makes one cycle in four eligible, 2'b10 one in two, and 2'b11 every cycle. The phase counter behind this starts at zero after reset and advances on every cycle in which `runEn` is 1.
- R9: While `dbgActive` is 1 and `dbgRunEn` is 0, `count` holds. While `dbgRunEn` is 1, the debug indication has no effect.
- R10: With `selfClrEn` at 1, `rstReq` stays high for exactly 32 clocks and then falls, even though no refresh arrives. With `selfClrEn` at 0 it stays high until a valid refresh.
- R11: Once high, `irqReq` and `rstReq` stay high even if their enables or thresholds change. Only a valid refresh or `rstN` clears them; the one exception is the self-release of R10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Function clock |
| rstN | input | 1 | Active-low asynchronous reset |
| runEn | input | 1 | Watchdog enable |
| dbgActive | input | 1 | Debug indication |
| dbgRunEn | input | 1 | Keep counting while in debug |
| lpActive | input | 1 | Low-power indication |
| lpMode | input | 2 | Low-power rate code |
| divSel | input | 3 | Prescaler exponent |
| winEn | input | 1 | Window mode enable |
| winLowSel | input | 2 | Window lower-bound code |
| winUpSel | input | 3 | Window upper-bound multiplier, 0 = none |
| selfClrEn | input | 1 | Self-release of the reset request |
| irqEn | input | 1 | Warning interrupt enable |
| rstEn | input | 1 | Timeout reset enable |
| irqThresh | input | 16 | Warning threshold |
| rstThresh | input | 16 | Timeout threshold |
| refWr | input | 1 | Refresh write strobe |
| refData | input | 32 | Refresh write data |
| irqReq | output | 1 | Warning interrupt request |
| rstReq | output | 1 | Timeout reset request |
| refViol | output | 1 | One-clock refresh violation pulse |
| count | output | 16 | Live counter value |

## Verification
The assertions assume that `selfClrEn` changes only while `rstN` is low. The bound on reset pulse width depends on this. They also assume that the refresh strobe is a level sampled at the clock edge. The bench meets both conditions: every scenario begins with a fresh reset, sets all configuration fields before releasing it, and drives each input on the falling edge. To hit an exact count for the window cases, the bench clears `runEn` to freeze the counter. It does this only after the thresholds have been chosen so that no request fires unexpectedly.

// File: rtl/winwdt_pkg.sv
package winwdt_pkg;
  typedef struct packed {
    logic advance;
    logic clear;
  } wdtStrobe_t;
endpackage

// File: rtl/winwdt_datapath.sv
module winwdt_datapath #(
  parameter int CNT_W = 16,
  parameter int DIV_W = 3
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  winwdt_pkg::wdtStrobe_t strobe,
  input  logic                   runEn,
  input  logic [DIV_W-1:0]       divSel,
  input  logic [1:0]             winLowSel,
  input  logic [2:0]             winUpSel,
  input  logic [CNT_W-1:0]       rstThresh,
  output logic [CNT_W-1:0]       count,
  output logic [1:0]             lpPhase,
  output logic                   inWindow
);
  localparam int PRE_W = (1 << DIV_W) - 1;
  localparam int LOW_W = CNT_W + 3;
  localparam int STEP_W = CNT_W - 4 + 3;
  localparam int UP_W = LOW_W + 1;

  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] preMask;
  logic             tick;
  logic [LOW_W-1:0] lowProd;
  logic [LOW_W-1:0] lowBound;
  logic [STEP_W-1:0] stepSize;
  logic [UP_W-1:0]  upBound;

  always_comb begin
    preMask = '0;
    for (int i = 0; i < PRE_W; i++) begin
      if (i < int'(divSel)) preMask[i] = 1'b1;
    end
  end

  assign tick = strobe.advance && ((preCnt & preMask) == preMask);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
      count  <= '0;
    end else if (strobe.clear) begin
      preCnt <= '0;
      count  <= '0;
    end else begin
      if (strobe.advance) preCnt <= preCnt + 1'b1;
      if (tick && count != '1) count <= count + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lpPhase <= '0;
    else if (runEn) lpPhase <= lpPhase + 1'b1;
  end

  assign lowProd  = LOW_W'(rstThresh) * LOW_W'(3'd4 + 3'(winLowSel));
  assign lowBound = lowProd >> 3;
  assign stepSize = STEP_W'(rstThresh >> 4) * STEP_W'(winUpSel);
  assign upBound  = UP_W'(lowBound) + UP_W'(stepSize);

  assign inWindow = (LOW_W'(count) >= lowBound) &&
                    ((winUpSel == '0) || (UP_W'(count) <= upBound));
endmodule

// File: rtl/winwdt_ctrl.sv
module winwdt_ctrl #(
  parameter int          CNT_W = 16,
  parameter logic [31:0] MAGIC = 32'h5A45_524F,
  parameter int          REL_CYC = 32
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   runEn,
  input  logic                   dbgActive,
  input  logic                   dbgRunEn,
  input  logic                   lpActive,
  input  logic [1:0]             lpMode,
  input  logic                   winEn,
  input  logic                   selfClrEn,
  input  logic                   irqEn,
  input  logic                   rstEn,
  input  logic [CNT_W-1:0]       irqThresh,
  input  logic [CNT_W-1:0]       rstThresh,
  input  logic                   refWr,
  input  logic [31:0]            refData,
  input  logic [CNT_W-1:0]       count,
  input  logic [1:0]             lpPhase,
  input  logic                   inWindow,
  output winwdt_pkg::wdtStrobe_t strobe,
  output logic                   irqReq,
  output logic                   rstReq,
  output logic                   refViol
);
  localparam int REL_W = $clog2(REL_CYC);

  logic lpOk, dbgOk, magicHit, validRef, badRef;
  logic irqFlag, rstFlag, relDone;
  logic [REL_W-1:0] relCnt;

  always_comb begin
    unique case (lpMode)
      2'b00:   lpOk = 1'b0;
      2'b01:   lpOk = (lpPhase == 2'b11);
      2'b10:   lpOk = lpPhase[0];
      default: lpOk = 1'b1;
    endcase
    if (!lpActive) lpOk = 1'b1;
  end

  assign dbgOk    = !dbgActive || dbgRunEn;
  assign magicHit = refWr && (refData == MAGIC);
  assign validRef = magicHit && (!winEn || inWindow);
  assign badRef   = refWr && !validRef;

  assign strobe.advance = runEn && dbgOk && lpOk;
  assign strobe.clear   = validRef;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqFlag <= 1'b0;
      rstFlag <= 1'b0;
      relDone <= 1'b0;
      relCnt  <= '0;
      refViol <= 1'b0;
    end else begin
      refViol <= badRef;
      if (validRef) begin
        irqFlag <= 1'b0;
        rstFlag <= 1'b0;
        relDone <= 1'b0;
        relCnt  <= '0;
      end else begin
        if (irqEn && runEn && count >= irqThresh) irqFlag <= 1'b1;
        if (rstEn && runEn && count >= rstThresh) rstFlag <= 1'b1;
        if (rstFlag && !relDone) begin
          if (relCnt == REL_W'(REL_CYC - 1)) relDone <= selfClrEn;
          else relCnt <= relCnt + 1'b1;
        end
      end
    end
  end

  assign irqReq = irqFlag;
  assign rstReq = rstFlag && !relDone;
endmodule

// File: rtl/winwdt_core.sv
module winwdt_core #(
  parameter int          CNT_W = 16,
  parameter int          DIV_W = 3,
  parameter logic [31:0] MAGIC = 32'h5A45_524F,
  parameter int          REL_CYC = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             runEn,
  input  logic             dbgActive,
  input  logic             dbgRunEn,
  input  logic             lpActive,
  input  logic [1:0]       lpMode,
  input  logic [DIV_W-1:0] divSel,
  input  logic             winEn,
  input  logic [1:0]       winLowSel,
  input  logic [2:0]       winUpSel,
  input  logic             selfClrEn,
  input  logic             irqEn,
  input  logic             rstEn,
  input  logic [CNT_W-1:0] irqThresh,
  input  logic [CNT_W-1:0] rstThresh,
  input  logic             refWr,
  input  logic [31:0]      refData,
  output logic             irqReq,
  output logic             rstReq,
  output logic             refViol,
  output logic [CNT_W-1:0] count
);
  winwdt_pkg::wdtStrobe_t strobe;
  logic [1:0] lpPhase;
  logic       inWindow;

  winwdt_ctrl #(.CNT_W(CNT_W), .MAGIC(MAGIC), .REL_CYC(REL_CYC)) u_ctrl (
    .clk(clk), .rstN(rstN), .runEn(runEn), .dbgActive(dbgActive),
    .dbgRunEn(dbgRunEn), .lpActive(lpActive), .lpMode(lpMode),
    .winEn(winEn), .selfClrEn(selfClrEn), .irqEn(irqEn), .rstEn(rstEn),
    .irqThresh(irqThresh), .rstThresh(rstThresh), .refWr(refWr),
    .refData(refData), .count(count), .lpPhase(lpPhase),
    .inWindow(inWindow), .strobe(strobe), .irqReq(irqReq),
    .rstReq(rstReq), .refViol(refViol)
  );

  winwdt_datapath #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .runEn(runEn),
    .divSel(divSel), .winLowSel(winLowSel), .winUpSel(winUpSel),
    .rstThresh(rstThresh), .count(count), .lpPhase(lpPhase),
    .inWindow(inWindow)
  );
endmodule

// File: rtl/winwdt_chk.sv
module winwdt_chk #(
  parameter int          CNT_W = 16,
  parameter logic [31:0] MAGIC = 32'h5A45_524F,
  parameter int          REL_CYC = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             runEn,
  input logic             dbgActive,
  input logic             dbgRunEn,
  input logic             lpActive,
  input logic [1:0]       lpMode,
  input logic             winEn,
  input logic             selfClrEn,
  input logic             irqEn,
  input logic             rstEn,
  input logic             refWr,
  input logic [31:0]      refData,
  input logic             irqReq,
  input logic             rstReq,
  input logic             refViol,
  input logic [CNT_W-1:0] count
);
  logic [7:0] hiCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) hiCnt <= '0;
    else if (rstReq) hiCnt <= (hiCnt == 8'hFF) ? hiCnt : hiCnt + 1'b1;
    else hiCnt <= '0;
  end

  // R1
  count_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(count) |-> (count == $past(count) + 1'b1) || (count == '0));

  // R9
  dbg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dbgActive && !dbgRunEn && !refWr) |=> $stable(count));

  // R8
  lp_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lpActive && lpMode == 2'b00 && !refWr) |=> $stable(count));

  // R4
  refresh_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (refWr && refData == MAGIC && !winEn) |=> (count == '0 && !irqReq && !rstReq));

  // R5
  bad_word_chk: assert property (@(posedge clk) disable iff (!rstN)
    (refWr && refData != MAGIC) |=> (refViol && $stable(count)));

  // R2
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqReq) |-> $past(irqEn && runEn));

  // R3
  rst_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstReq) |-> $past(rstEn && runEn));

  // R11
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irqReq) |-> $past(refWr && refData == MAGIC));

  // R10
  rst_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rstReq && selfClrEn) |-> (hiCnt < 8'(REL_CYC)));
endmodule

bind winwdt_core winwdt_chk #(.CNT_W(CNT_W), .MAGIC(MAGIC), .REL_CYC(REL_CYC)) u_chk (
  .clk(clk), .rstN(rstN), .runEn(runEn), .dbgActive(dbgActive),
  .dbgRunEn(dbgRunEn), .lpActive(lpActive), .lpMode(lpMode), .winEn(winEn),
  .selfClrEn(selfClrEn), .irqEn(irqEn), .rstEn(rstEn), .refWr(refWr),
  .refData(refData), .irqReq(irqReq), .rstReq(rstReq), .refViol(refViol),
  .count(count)
);

// File: tb/winwdt_core_tb.sv
module winwdt_core_tb;
  localparam logic [31:0] GOOD = 32'h5A45_524F;

  logic clk = 1'b0;
  logic rstN, runEn, dbgActive, dbgRunEn, lpActive, winEn, selfClrEn, irqEn, rstEn, refWr;
  logic [1:0] lpMode, winLowSel;
  logic [2:0] divSel, winUpSel;
  logic [15:0] irqThresh, rstThresh, count;
  logic [31:0] refData;
  logic irqReq, rstReq, refViol;
  int errors = 0;
  int checks = 0;
  bit timedOut = 1'b0;

  always #5 clk = ~clk;

  winwdt_core u_dut (
    .clk(clk), .rstN(rstN), .runEn(runEn), .dbgActive(dbgActive),
    .dbgRunEn(dbgRunEn), .lpActive(lpActive), .lpMode(lpMode),
    .divSel(divSel), .winEn(winEn), .winLowSel(winLowSel),
    .winUpSel(winUpSel), .selfClrEn(selfClrEn), .irqEn(irqEn),
    .rstEn(rstEn), .irqThresh(irqThresh), .rstThresh(rstThresh),
    .refWr(refWr), .refData(refData), .irqReq(irqReq), .rstReq(rstReq),
    .refViol(refViol), .count(count)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic freshStart(input logic selfClr);
    @(negedge clk);
    rstN = 1'b0; runEn = 1'b0; dbgActive = 1'b0; dbgRunEn = 1'b0;
    lpActive = 1'b0; lpMode = 2'b11; divSel = '0; winEn = 1'b0;
    winLowSel = '0; winUpSel = '0; selfClrEn = selfClr; irqEn = 1'b0;
    rstEn = 1'b0; irqThresh = 16'hFFFF; rstThresh = 16'hFFFF;
    refWr = 1'b0; refData = '0;
    cycles(2);
    rstN = 1'b1;
  endtask

  task automatic writeRef(input logic [31:0] d);
    refWr = 1'b1; refData = d;
    cycles(1);
    refWr = 1'b0; refData = '0;
  endtask

  task automatic runTo(input int n);
    runEn = 1'b1;
    cycles(n);
    runEn = 1'b0;
  endtask

  task automatic testResetAndPrescale();
    freshStart(1'b0);
    check("R1 reset count", 32'(count), 0);
    check("R2 reset irqReq", 32'(irqReq), 0);
    check("R3 reset rstReq", 32'(rstReq), 0);
    divSel = 3'd0; runTo(7);
    check("R1 div1", 32'(count), 7);
    freshStart(1'b0);
    divSel = 3'd2; runTo(8);
    check("R1 div4", 32'(count), 2);
    freshStart(1'b0);
    divSel = 3'd3; runTo(17);
    check("R1 div8", 32'(count), 2);
  endtask

  task automatic testIrq();
    freshStart(1'b0);
    irqEn = 1'b1; irqThresh = 16'd5;
    runEn = 1'b1;
    cycles(5);
    check("R2 not yet", 32'(irqReq), 0);
    cycles(1);
    check("R2 raised", 32'(irqReq), 1);
    irqEn = 1'b0; irqThresh = 16'hFFFF;
    cycles(3);
    check("R11 irq sticky", 32'(irqReq), 1);
    writeRef(GOOD);
    check("R4 count cleared", 32'(count), 0);
    check("R4 irq cleared", 32'(irqReq), 0);
    freshStart(1'b0);
    irqThresh = 16'd3; runTo(20);
    check("R2 gated off", 32'(irqReq), 0);
  endtask

  task automatic testRst();
    freshStart(1'b0);
    rstEn = 1'b1; rstThresh = 16'd10; runEn = 1'b1;
    cycles(10);
    check("R3 not yet", 32'(rstReq), 0);
    cycles(1);
    check("R3 raised", 32'(rstReq), 1);
    cycles(60);
    check("R10 no self release", 32'(rstReq), 1);
    writeRef(GOOD);
    check("R4 rst cleared", 32'(rstReq), 0);
    freshStart(1'b1);
    rstEn = 1'b1; rstThresh = 16'd10; runEn = 1'b1;
    cycles(42);
    check("R10 high at 32nd", 32'(rstReq), 1);
    cycles(1);
    check("R10 released", 32'(rstReq), 0);
    cycles(20);
    check("R10 stays released", 32'(rstReq), 0);
  endtask

  task automatic testBadWord();
    freshStart(1'b0);
    irqEn = 1'b1; irqThresh = 16'd4;
    runTo(12);
    writeRef(32'h5A45_524E);
    check("R5 viol pulse", 32'(refViol), 1);
    check("R5 count kept", 32'(count), 12);
    check("R5 irq kept", 32'(irqReq), 1);
    cycles(1);
    check("R5 pulse one clock", 32'(refViol), 0);
  endtask

  task automatic testWindow();
    freshStart(1'b0);
    winEn = 1'b1; rstThresh = 16'd64; winLowSel = 2'd0;
    runTo(31);
    writeRef(GOOD);
    check("R6 below 4/8 rejected", 32'(refViol), 1);
    check("R6 count kept", 32'(count), 31);
    runTo(1);
    writeRef(GOOD);
    check("R6 at 4/8 accepted", 32'(refViol), 0);
    check("R6 count cleared", 32'(count), 0);
    freshStart(1'b0);
    winEn = 1'b1; rstThresh = 16'd64; winLowSel = 2'd3;
    runTo(55);
    writeRef(GOOD);
    check("R6 below 7/8 rejected", 32'(refViol), 1);
    freshStart(1'b0);
    winEn = 1'b1; rstThresh = 16'd64; winLowSel = 2'd0; winUpSel = 3'd1;
    runTo(37);
    writeRef(GOOD);
    check("R7 above upper rejected", 32'(refViol), 1);
    check("R7 count kept", 32'(count), 37);
    freshStart(1'b0);
    winEn = 1'b1; rstThresh = 16'd64; winLowSel = 2'd0; winUpSel = 3'd1;
    runTo(36);
    writeRef(GOOD);
    check("R7 at upper accepted", 32'(count), 0);
    freshStart(1'b0);
    winEn = 1'b1; rstThresh = 16'd64; winUpSel = 3'd0;
    runTo(60);
    writeRef(GOOD);
    check("R7 no upper bound", 32'(refViol), 0);
  endtask

  task automatic testLowPower();
    freshStart(1'b0);
    lpActive = 1'b1; lpMode = 2'b10; runTo(8);
    check("R8 half rate", 32'(count), 4);
    freshStart(1'b0);
    lpActive = 1'b1; lpMode = 2'b01; runTo(8);
    check("R8 quarter rate", 32'(count), 2);
    freshStart(1'b0);
    lpActive = 1'b1; lpMode = 2'b00; runTo(8);
    check("R8 halted", 32'(count), 0);
    freshStart(1'b0);
    lpActive = 1'b1; lpMode = 2'b11; runTo(8);
    check("R8 full rate", 32'(count), 8);
  endtask

  task automatic testDebug();
    freshStart(1'b0);
    dbgActive = 1'b1; dbgRunEn = 1'b0; runTo(8);
    check("R9 held in debug", 32'(count), 0);
    freshStart(1'b0);
    dbgActive = 1'b1; dbgRunEn = 1'b1; runTo(8);
    check("R9 runs in debug", 32'(count), 8);
  endtask

  initial begin
    fork
      begin
        testResetAndPrescale();
        testIrq();
        testRst();
        testBadWord();
        testWindow();
        testLowPower();
        testDebug();
      end
      begin
        repeat (150000) @(posedge clk);
        timedOut = 1'b1;
      end
    join_any
    disable fork;
    if (timedOut) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule